// File: doc/BRIEF.md
# Multi-Precision Integer Dot-Product Accumulator

This block is a multiply-accumulate unit for integer neural-network inference. It takes two 16-bit operand words, a signed 16-bit addend and a 2-bit precision select. The select sets how both operand words are cut into equal lanes: one 16-bit lane, two 8-bit lanes, four 4-bit lanes, or eight 1-bit lanes. Matching lanes of the two words are multiplied. In the 1-bit case the lanes are ANDed. The lane results are then added together with the addend to give one sum.

The same operand words feed every precision, so a caller packs narrower data into the word it already has. A binary network uses the 1-bit setting, where the sum is the count of positions in which both inputs are 1. The unit has two register stages. Lane products are captured first, and the folded sum second. A new operation can start on every cycle, and `res_valid` tracks `in_valid` with a fixed delay.

Top module: `pdm_mac`

## Requirements
- R1: With `prec` = 2'b00, `result` equals the signed product of `op_a` and `op_b`, each read as a 16-bit two's-complement value, plus the signed `addend`.
- R2: With `prec` = 2'b01, both words are split into two signed 8-bit lanes, lane i being bits [8i+7:8i]. `result` is the sum of the two lane products plus `addend`.
- R3: With `prec` = 2'b10, both words are split into four signed 4-bit lanes, lane i being bits [4i+3:4i]. `result` is the sum of the four lane products plus `addend`.
- R4: With `prec` = 2'b11, `result` is `addend` plus the number of set bits in `op_a[7:0] & op_b[7:0]`. Bits [15:8] of both words have no effect on the result.
- R5: `result` is 34 bits wide and sign-extended. No combination of inputs overflows it, including every lane at its most negative value together with an extreme addend.
- R6: `res_valid` is high exactly two clock edges after an edge where `in_valid` was sampled high, and low otherwise. Back-to-back inputs give back-to-back results.
- R7: A synchronous active-high `rst` clears both pipeline valid bits and the result register, so `res_valid` is 0 and `result` is 0 after reset.
- R8: When `res_valid` is low, `result` keeps the last valid result, or 0 if no result has been produced since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands present this cycle |
| prec | input | 2 | Lane split: 00 = 1x16, 01 = 2x8, 10 = 4x4, 11 = 8x1 |
| op_a | input | 16 | First operand word |
| op_b | input | 16 | Second operand word |
| addend | input | 16 | Signed addend |
| res_valid | output | 1 | Result valid |
| result | output | 34 | Signed accumulated sum |

## Verification
The bench drives all lanes at their most negative value in each signed setting. A design that sign-extends a lane product wrongly, or truncates the sum, returns a large positive or wrapped value there instead of the exact square sum. In the 1-bit setting the bench sets only the upper byte of both words and expects the addend unchanged, which catches a count taken over all 16 bits. Random cycles with gaps in `in_valid` expose an off-by-one in latency, a stale lane from a previous precision, and a result register that changes while `res_valid` is low.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
    localparam int OP_W   = 16;
    localparam int NTERM  = 8;
    localparam int PROD_W = 2 * OP_W;

    typedef enum logic [1:0] {
        PREC_W16 = 2'b00,
        PREC_W8  = 2'b01,
        PREC_W4  = 2'b10,
        PREC_W1  = 2'b11
    } prec_e;
endpackage

// File: rtl/pdm_lane_mul.sv
module pdm_lane_mul #(
    parameter int OP_W  = 16,
    parameter int LANES = 1,
    localparam int LW   = OP_W / LANES,
    localparam int PW   = 2 * LW
) (
    input  logic [OP_W-1:0]           a,
    input  logic [OP_W-1:0]           b,
    output logic [LANES-1:0][PW-1:0]  prod
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [LW-1:0] sa;
        logic signed [LW-1:0] sb;
        assign sa      = a[g*LW +: LW];
        assign sb      = b[g*LW +: LW];
        assign prod[g] = PW'(sa) * PW'(sb);
    end
endmodule

// File: rtl/pdm_and_count.sv
module pdm_and_count #(
    parameter int BITS = 8,
    localparam int CW  = $clog2(BITS + 1)
) (
    input  logic [BITS-1:0] a,
    input  logic [BITS-1:0] b,
    output logic [CW-1:0]   count
);
    always_comb begin
        count = '0;
        for (int i = 0; i < BITS; i++) begin
            count = count + CW'(a[i] & b[i]);
        end
    end
endmodule

// File: rtl/pdm_fold.sv
module pdm_fold #(
    parameter int NTERM  = 8,
    parameter int PROD_W = 32,
    parameter int ADD_W  = 16,
    parameter int ACC_W  = 34
) (
    input  logic [NTERM-1:0][PROD_W-1:0] terms,
    input  logic [ADD_W-1:0]             addend,
    output logic [ACC_W-1:0]             sum
);
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'(signed'(addend));
        for (int i = 0; i < NTERM; i++) begin
            acc = acc + ACC_W'(signed'(terms[i]));
        end
        sum = acc;
    end
endmodule

// File: rtl/pdm_mac.sv
module pdm_mac
    import pdm_pkg::*;
#(
    parameter int ACC_W = 34
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       prec,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [OP_W-1:0]  addend,
    output logic             res_valid,
    output logic [ACC_W-1:0] result
);
    localparam int BIN_LANES = 8;
    localparam int CNT_W     = $clog2(BIN_LANES + 1);

    typedef struct packed {
        logic                            valid;
        prec_e                           prec;
        logic [OP_W-1:0]                 addend;
        logic [NTERM-1:0][PROD_W-1:0]    terms;
    } s1_t;

    typedef struct packed {
        logic             valid;
        logic [ACC_W-1:0] result;
    } s2_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;

    logic [0:0][2*OP_W-1:0]  p16;
    logic [1:0][OP_W-1:0]    p8;
    logic [3:0][OP_W/2-1:0]  p4;
    logic [CNT_W-1:0]        bin_cnt;
    logic [ACC_W-1:0]        fold_sum;

    pdm_lane_mul #(.OP_W(OP_W), .LANES(1)) u_mul16 (.a(op_a), .b(op_b), .prod(p16));
    pdm_lane_mul #(.OP_W(OP_W), .LANES(2)) u_mul8  (.a(op_a), .b(op_b), .prod(p8));
    pdm_lane_mul #(.OP_W(OP_W), .LANES(4)) u_mul4  (.a(op_a), .b(op_b), .prod(p4));

    pdm_and_count #(.BITS(BIN_LANES)) u_cnt (
        .a     (op_a[BIN_LANES-1:0]),
        .b     (op_b[BIN_LANES-1:0]),
        .count (bin_cnt)
    );

    pdm_fold #(.NTERM(NTERM), .PROD_W(PROD_W), .ADD_W(OP_W), .ACC_W(ACC_W)) u_fold (
        .terms  (s1_q.terms),
        .addend (s1_q.addend),
        .sum    (fold_sum)
    );

    always_comb begin
        s1_d        = '0;
        s1_d.valid  = in_valid;
        s1_d.prec   = prec_e'(prec);
        s1_d.addend = addend;
        case (prec_e'(prec))
            PREC_W16: s1_d.terms[0] = p16[0];
            PREC_W8: begin
                for (int i = 0; i < 2; i++) s1_d.terms[i] = PROD_W'(signed'(p8[i]));
            end
            PREC_W4: begin
                for (int i = 0; i < 4; i++) s1_d.terms[i] = PROD_W'(signed'(p4[i]));
            end
            default: s1_d.terms[0] = PROD_W'(bin_cnt);
        endcase

        s2_d       = s2_q;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) s2_d.result = fold_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign res_valid = s2_q.valid;
    assign result    = s2_q.result;

    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (!s1_q.valid && !s2_q.valid && s2_q.result == '0));

    p_stage_handoff_r6: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid |=> s2_q.valid);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
        !s1_q.valid |=> !s2_q.valid);

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !s1_q.valid |=> $stable(s2_q.result));

    p_bin_range_r4: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.prec == PREC_W1) |->
        (s1_q.terms[0] <= PROD_W'(BIN_LANES) && s1_q.terms[NTERM-1:1] == '0));

    p_lane_clear_r1: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.prec == PREC_W16) |-> s1_q.terms[NTERM-1:1] == '0);

    p_lane_clear_r2: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.prec == PREC_W8) |-> s1_q.terms[NTERM-1:2] == '0);

    p_lane_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.prec == PREC_W4) |-> s1_q.terms[NTERM-1:4] == '0);

    p_bound_r5: assert property (@(posedge clk) disable iff (rst)
        s2_q.valid |-> ($signed(s2_q.result) <= $signed(ACC_W'(64'sd1073807360)) &&
                        $signed(s2_q.result) >= $signed(ACC_W'(-64'sd1073774592))));
endmodule

// File: tb/pdm_mac_tb.sv
module pdm_mac_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  prec;
    logic [15:0] op_a, op_b, addend;
    logic        res_valid;
    logic [33:0] result;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    pdm_mac u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .prec(prec),
        .op_a(op_a), .op_b(op_b), .addend(addend),
        .res_valid(res_valid), .result(result)
    );

    function automatic longint lane_val(input logic [15:0] w, input int idx, input int lw);
        longint v = longint'((w >> (idx * lw)) & ((1 << lw) - 1));
        if (v >= (longint'(1) << (lw - 1))) v = v - (longint'(1) << lw);
        return v;
    endfunction

    function automatic longint ref_mac(input logic [1:0] m, input logic [15:0] a,
                                       input logic [15:0] b, input logic [15:0] c);
        longint s = longint'($signed(c));
        if (m == 2'b11) begin
            for (int i = 0; i < 8; i++) s += longint'(a[i] & b[i]);
        end else begin
            int lw = (m == 2'b00) ? 16 : (m == 2'b01) ? 8 : 4;
            for (int i = 0; i < 16 / lw; i++) s += lane_val(a, i, lw) * lane_val(b, i, lw);
        end
        return s;
    endfunction

    function automatic string tag_of(input logic [1:0] m);
        case (m)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    bit     h_v[2];
    longint h_e[2];
    string  h_t[2];
    longint last_res = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [1:0] m, input logic [15:0] a,
                        input logic [15:0] b, input logic [15:0] c, input string tag);
        @(negedge clk);
        check(res_valid == h_v[1], "R6", longint'(res_valid), longint'(h_v[1]));
        if (h_v[1]) begin
            check($signed(result) == h_e[1], h_t[1], $signed(result), h_e[1]);
            last_res = h_e[1];
        end else begin
            check($signed(result) == last_res, "R8", $signed(result), last_res);
        end
        h_v[1] = h_v[0]; h_e[1] = h_e[0]; h_t[1] = h_t[0];
        h_v[0] = v; h_e[0] = ref_mac(m, a, b, c); h_t[0] = tag;
        in_valid = v; prec = m; op_a = a; op_b = b; addend = c;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; prec = 2'b00; op_a = '0; op_b = '0; addend = '0;
        for (int i = 0; i < 2; i++) begin h_v[i] = 0; h_e[i] = 0; h_t[i] = "R7"; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(res_valid == 1'b0, "R7", longint'(res_valid), 0);
        check(result == '0, "R7", $signed(result), 0);
        rst = 1'b0;

        // R5 corners: every lane at its most negative value
        step(1, 2'b00, 16'h8000, 16'h8000, 16'h7FFF, "R5");
        step(1, 2'b00, 16'h8000, 16'h7FFF, 16'h8000, "R5");
        step(1, 2'b01, 16'h8080, 16'h8080, 16'h8000, "R5");
        step(1, 2'b10, 16'h8888, 16'h8888, 16'h7FFF, "R5");
        step(1, 2'b10, 16'h8888, 16'h7777, 16'h8000, "R5");
        // R4: all ones, and only the ignored upper byte set
        step(1, 2'b11, 16'hFFFF, 16'hFFFF, 16'h0005, "R4");
        step(1, 2'b11, 16'hFF00, 16'hFF00, 16'h1234, "R4");
        step(1, 2'b11, 16'h00A5, 16'h00FF, 16'hFFFF, "R4");
        // gap: R8 hold and R6 no spurious valid
        step(0, 2'b00, 16'h1111, 16'h2222, 16'h0000, "R8");
        step(0, 2'b01, 16'h3333, 16'h4444, 16'h0000, "R8");
        step(0, 2'b10, 16'h0000, 16'h0000, 16'h0000, "R8");
        step(1, 2'b01, 16'h7F80, 16'h807F, 16'h0001, "R2");

        for (int n = 0; n < 600; n++) begin
            logic [1:0] m = 2'($urandom_range(0, 3));
            bit v = ($urandom_range(0, 3) != 0);
            step(v, m, 16'($urandom), 16'($urandom), 16'($urandom), tag_of(m));
        end
        step(0, 2'b00, 16'h0, 16'h0, 16'h0, "R6");
        step(0, 2'b00, 16'h0, 16'h0, 16'h0, "R6");
        step(0, 2'b00, 16'h0, 16'h0, 16'h0, "R8");

        // R7: reset mid-stream clears valid and result
        @(negedge clk); in_valid = 1'b1; rst = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        check(res_valid == 1'b0, "R7", longint'(res_valid), 0);
        check(result == '0, "R7", $signed(result), 0);
        rst = 1'b0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule